// File: doc/BRIEF.md
# Data Access Fault Classifier

This block sits behind a data translation lookaside buffer. Once a lookup has hit, it takes the attribute bits of the matching entry together with the kind of access, the mode of the requester and the chosen address space. From these it decides whether the access may proceed. A granted access returns a permission set. A refused access returns either a data access fault or a data protection fault.

On a refusal the block also writes three registers: a fault status word, a fault address register and a tag-access register. The trap handler reads these registers. Software clears the status valid bit with an explicit clear strobe once it has consumed a report. The result comes back one cycle after the request. Several access-fault causes can be reported at the same time, and a write-permission fault is reported only when no access fault is present.

Access kind encoding: 0 load, 1 store, 2 non-faulting load, 3 plain load. Context selection encoding: 0 primary, 1 secondary, 2 nucleus, 3 nucleus. Exception encoding: 0 none, 1 data access fault, 2 data protection fault.

Top module: `dacc_fault_classifier`

## Requirements
- R1: After reset the response valid flag, the status word, the fault address and the tag-access register all read zero.
- R2: A user-mode access (acc_user=1) to an entry marked privileged raises exception 1 and sets status bit 7. The same access in privileged mode is granted.
- R3: A non-faulting load to a side-effect entry raises exception 1 and sets status bit 8. A load or store to a no-fault-only entry raises exception 1 and sets status bit 9. A non-faulting load to a no-fault-only entry without the side-effect mark is granted.
- R4: Fault causes accumulate: when more than one cause applies, all of their status bits are set together and the exception is 1.
- R5: A store to an entry without the writable mark raises exception 2 only when no access-fault cause applies. In that case status bits 9:7 are zero. If an access-fault cause does apply, the exception is 1.
- R6: The response appears on the cycle after the request. A granted access reports read permission, and write permission exactly when the entry is writable. A refused access reports neither permission.
- R7: Status bits 4:3 hold the context type: 0 primary, 1 secondary, 2 nucleus (selection 2 or 3). The context used is the primary value, the secondary value, or zero for nucleus.
- R8: Status bit 5 is set for a store and bit 6 for a non-faulting load; otherwise both are clear.
- R9: On every fault, status bit 0 (valid) is set. Bit 1 (overwrite) copies the valid bit present before the fault. Bit 2 copies cpu_priv.
- R10: On every fault the fault address register takes the full virtual address. The tag-access register takes the address with its low CTX_W bits replaced by the context.
- R11: The status, fault address and tag-access registers keep their values on granted accesses and idle cycles. The clear strobe zeroes only status bit 0, and it acts before a fault that arrives in the same cycle, so that fault reports overwrite 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A TLB hit is presented this cycle |
| va | input | VA_W | Virtual address of the access |
| attr_priv | input | 1 | Entry is privileged-only |
| attr_wr_ok | input | 1 | Entry is writable |
| attr_side_eff | input | 1 | Entry has side effects |
| attr_nfo | input | 1 | Entry is for non-faulting loads only |
| acc_kind | input | 2 | Access kind code |
| acc_user | input | 1 | Access made in user mode |
| cpu_priv | input | 1 | Processor privileged state |
| ctx_sel | input | 2 | Context selection code |
| ctx_primary | input | CTX_W | Primary context value |
| ctx_secondary | input | CTX_W | Secondary context value |
| stat_clr | input | 1 | Clear strobe for the status valid bit |
| rsp_valid | output | 1 | Response valid |
| rsp_exc | output | 2 | Exception code |
| rsp_perm_rd | output | 1 | Read permission granted |
| rsp_perm_wr | output | 1 | Write permission granted |
| stat_word | output | 10 | Fault status word |
| fault_addr | output | VA_W | Fault address register |
| tag_access | output | VA_W | Tag-access register |

## Verification
The main decision is exercised one cause at a time first: privilege violation, non-faulting load to a side-effect entry, no-fault-only entry, and a store to a read-only entry. This separates each status bit and each exception code. Paired patterns then combine causes, such as a user store to a privileged no-fault-only entry and a user store to a privileged read-only entry. These show whether bits accumulate and whether access faults outrank protection faults. Granted patterns (privileged access to a privileged entry, non-faulting load to a plain no-fault-only entry, read-only versus writable loads) check the permission outputs and confirm that no register moved. Back-to-back faults, a lone clear and a clear coinciding with a fault separate the overwrite behaviour cases.

// File: rtl/dafc_pkg.sv
package dafc_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD   = 2'd0,
      ACC_STORE  = 2'd1,
      ACC_NFLOAD = 2'd2,
      ACC_LOAD2  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      SEL_PRIMARY   = 2'd0,
      SEL_SECONDARY = 2'd1,
      SEL_NUCLEUS   = 2'd2,
      SEL_NUCLEUS2  = 2'd3
   } ctx_sel_e;

   typedef enum logic [1:0] {
      EXC_NONE   = 2'd0,
      EXC_ACCESS = 2'd1,
      EXC_PROT   = 2'd2
   } exc_e;

   typedef struct packed {
      logic nfo;
      logic side_eff;
      logic wr_ok;
      logic priv;
   } attr_t;

   // fault cause vector: [0] privilege, [1] nf-load side effect, [2] no-fault-only
   localparam int FT_W = 3;

   // status word layout
   localparam int ST_W      = 10;
   localparam int ST_VALID  = 0;
   localparam int ST_OVWR   = 1;
   localparam int ST_PRIV   = 2;
   localparam int ST_CTX_LO = 3;
   localparam int ST_WRITE  = 5;
   localparam int ST_NFLD   = 6;
   localparam int ST_FT_LO  = 7;

endpackage

// File: rtl/dafc_ctx_pick.sv
module dafc_ctx_pick
   import dafc_pkg::*;
#(
   parameter int CTX_W = 13
) (
   input  logic [1:0]       sel,
   input  logic [CTX_W-1:0] primary,
   input  logic [CTX_W-1:0] secondary,
   output logic [CTX_W-1:0] ctx_val,
   output logic [1:0]       ctx_type
);

   ctx_sel_e sel_e;
   assign sel_e = ctx_sel_e'(sel);

   always_comb begin
      unique case (sel_e)
         SEL_PRIMARY: begin
            ctx_val  = primary;
            ctx_type = 2'd0;
         end
         SEL_SECONDARY: begin
            ctx_val  = secondary;
            ctx_type = 2'd1;
         end
         default: begin
            ctx_val  = '0;
            ctx_type = 2'd2;
         end
      endcase
   end

endmodule

// File: rtl/dafc_fault_eval.sv
module dafc_fault_eval
   import dafc_pkg::*;
(
   input  attr_t             attr,
   input  logic [1:0]        kind,
   input  logic              user,
   output logic [FT_W-1:0]   ft,
   output logic [1:0]        exc,
   output logic              perm_rd,
   output logic              perm_wr
);

   acc_kind_e kind_e;
   logic      is_nf, is_store, any_acc, prot;

   assign kind_e   = acc_kind_e'(kind);
   assign is_nf    = (kind_e == ACC_NFLOAD);
   assign is_store = (kind_e == ACC_STORE);

   // independent causes, all may be set together
   assign ft[0] = attr.priv & user;
   assign ft[1] = is_nf & attr.side_eff;
   assign ft[2] = ~is_nf & attr.nfo;

   assign any_acc = |ft;
   // write permission is examined only without an access fault
   assign prot    = ~any_acc & is_store & ~attr.wr_ok;

   always_comb begin
      if (any_acc)   exc = EXC_ACCESS;
      else if (prot) exc = EXC_PROT;
      else           exc = EXC_NONE;
   end

   assign perm_rd = ~any_acc & ~prot;
   assign perm_wr = ~any_acc & ~prot & attr.wr_ok;

endmodule

// File: rtl/dafc_state.sv
module dafc_state
   import dafc_pkg::*;
#(
   parameter int VA_W    = 64,
   parameter int CTX_W   = 13,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   va,
   input  logic [CTX_W-1:0]  ctx_val,
   input  logic [1:0]        ctx_type,
   input  logic [1:0]        kind,
   input  logic              cpu_priv,
   input  logic [FT_W-1:0]   ft,
   input  logic [1:0]        exc,
   input  logic              perm_rd,
   input  logic              perm_wr,
   input  logic              stat_clr,
   output logic              rsp_valid,
   output logic [1:0]        rsp_exc,
   output logic              rsp_perm_rd,
   output logic              rsp_perm_wr,
   output logic [ST_W-1:0]   stat_q,
   output logic [VA_W-1:0]   far_q,
   output logic [VA_W-1:0]   tag_q
);

   localparam int HI_W = VA_W - CTX_W;

   logic            fault;
   logic [ST_W-1:0] stat_base, stat_new;
   acc_kind_e       kind_e;

   assign kind_e = acc_kind_e'(kind);
   assign fault  = req_valid & (exc != EXC_NONE);

   always_comb begin
      stat_base = stat_q;
      if (stat_clr) stat_base[ST_VALID] = 1'b0;
      stat_new                          = '0;
      stat_new[ST_VALID]                = 1'b1;
      stat_new[ST_OVWR]                 = stat_base[ST_VALID];
      stat_new[ST_PRIV]                 = cpu_priv;
      stat_new[ST_CTX_LO +: 2]          = ctx_type;
      stat_new[ST_WRITE]                = (kind_e == ACC_STORE);
      stat_new[ST_NFLD]                 = (kind_e == ACC_NFLOAD);
      stat_new[ST_FT_LO +: FT_W]        = ft;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         far_q  <= '0;
         tag_q  <= '0;
      end else if (fault) begin
         stat_q <= stat_new;
         far_q  <= va;
         tag_q  <= {va[VA_W-1 -: HI_W], ctx_val};
      end else begin
         stat_q <= stat_base;
      end
   end

   generate
      if (OUT_REG) begin : g_reg_rsp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rsp_valid   <= 1'b0;
               rsp_exc     <= EXC_NONE;
               rsp_perm_rd <= 1'b0;
               rsp_perm_wr <= 1'b0;
            end else begin
               rsp_valid   <= req_valid;
               rsp_exc     <= req_valid ? exc     : EXC_NONE;
               rsp_perm_rd <= req_valid & perm_rd;
               rsp_perm_wr <= req_valid & perm_wr;
            end
         end
      end else begin : g_comb_rsp
         assign rsp_valid   = req_valid;
         assign rsp_exc     = req_valid ? exc : EXC_NONE;
         assign rsp_perm_rd = req_valid & perm_rd;
         assign rsp_perm_wr = req_valid & perm_wr;
      end
   endgenerate

   // R9
   stat_valid_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> stat_q[ST_VALID]);

   // R11
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault && !stat_clr) |=> $stable(stat_q));

   // R10
   far_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |=> ($stable(far_q) && $stable(tag_q)));

   // R11
   clr_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !fault) |=> (!stat_q[ST_VALID] &&
                                stat_q[ST_W-1:1] == $past(stat_q[ST_W-1:1])));

endmodule

// File: rtl/dacc_fault_classifier.sv
module dacc_fault_classifier
   import dafc_pkg::*;
#(
   parameter int VA_W    = 64,
   parameter int CTX_W   = 13,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   va,
   input  logic              attr_priv,
   input  logic              attr_wr_ok,
   input  logic              attr_side_eff,
   input  logic              attr_nfo,
   input  logic [1:0]        acc_kind,
   input  logic              acc_user,
   input  logic              cpu_priv,
   input  logic [1:0]        ctx_sel,
   input  logic [CTX_W-1:0]  ctx_primary,
   input  logic [CTX_W-1:0]  ctx_secondary,
   input  logic              stat_clr,
   output logic              rsp_valid,
   output logic [1:0]        rsp_exc,
   output logic              rsp_perm_rd,
   output logic              rsp_perm_wr,
   output logic [9:0]        stat_word,
   output logic [VA_W-1:0]   fault_addr,
   output logic [VA_W-1:0]   tag_access
);

   generate
      if (CTX_W < 1 || CTX_W >= VA_W) begin : g_bad_ctx
         $error("CTX_W must be between 1 and VA_W-1");
      end
      if (ST_W != 10) begin : g_bad_st
         $error("status word width mismatch");
      end
   endgenerate

   attr_t            attr;
   logic [CTX_W-1:0] ctx_val;
   logic [1:0]       ctx_type;
   logic [FT_W-1:0]  ft;
   logic [1:0]       exc;
   logic             perm_rd, perm_wr;

   assign attr = '{nfo: attr_nfo, side_eff: attr_side_eff,
                   wr_ok: attr_wr_ok, priv: attr_priv};

   dafc_ctx_pick #(.CTX_W(CTX_W)) u_ctx (
      .sel       (ctx_sel),
      .primary   (ctx_primary),
      .secondary (ctx_secondary),
      .ctx_val   (ctx_val),
      .ctx_type  (ctx_type)
   );

   dafc_fault_eval u_eval (
      .attr    (attr),
      .kind    (acc_kind),
      .user    (acc_user),
      .ft      (ft),
      .exc     (exc),
      .perm_rd (perm_rd),
      .perm_wr (perm_wr)
   );

   dafc_state #(.VA_W(VA_W), .CTX_W(CTX_W), .OUT_REG(OUT_REG)) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .va          (va),
      .ctx_val     (ctx_val),
      .ctx_type    (ctx_type),
      .kind        (acc_kind),
      .cpu_priv    (cpu_priv),
      .ft          (ft),
      .exc         (exc),
      .perm_rd     (perm_rd),
      .perm_wr     (perm_wr),
      .stat_clr    (stat_clr),
      .rsp_valid   (rsp_valid),
      .rsp_exc     (rsp_exc),
      .rsp_perm_rd (rsp_perm_rd),
      .rsp_perm_wr (rsp_perm_wr),
      .stat_q      (stat_word),
      .far_q       (fault_addr),
      .tag_q       (tag_access)
   );

   // R6
   no_perm_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_exc != EXC_NONE) |-> (!rsp_perm_rd && !rsp_perm_wr));

   // R5
   prot_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_exc == EXC_PROT) |-> (stat_word[ST_FT_LO +: FT_W] == '0 && stat_word[ST_WRITE]));

   // R4
   access_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_exc == EXC_ACCESS) |-> (stat_word[ST_FT_LO +: FT_W] != '0 && stat_word[ST_VALID]));

endmodule

// File: tb/tb_dacc_fault_classifier.sv
module tb_dacc_fault_classifier;

   localparam int VA_W  = 64;
   localparam int CTX_W = 13;
   localparam logic [CTX_W-1:0] PCTX = 13'h0A5;
   localparam logic [CTX_W-1:0] SCTX = 13'h1F3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [VA_W-1:0]   va = '0;
   logic              attr_priv = 1'b0, attr_wr_ok = 1'b0, attr_side_eff = 1'b0, attr_nfo = 1'b0;
   logic [1:0]        acc_kind = 2'd0;
   logic              acc_user = 1'b0, cpu_priv = 1'b0;
   logic [1:0]        ctx_sel = 2'd0;
   logic              stat_clr = 1'b0;
   logic              rsp_valid, rsp_perm_rd, rsp_perm_wr;
   logic [1:0]        rsp_exc;
   logic [9:0]        stat_word;
   logic [VA_W-1:0]   fault_addr, tag_access;

   int n_chk = 0, n_fail = 0;
   logic [9:0]      m_stat = '0;
   logic [VA_W-1:0] m_far = '0, m_tag = '0;

   always #10 clk = ~clk;

   dacc_fault_classifier #(.VA_W(VA_W), .CTX_W(CTX_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va),
      .attr_priv(attr_priv), .attr_wr_ok(attr_wr_ok), .attr_side_eff(attr_side_eff),
      .attr_nfo(attr_nfo), .acc_kind(acc_kind), .acc_user(acc_user), .cpu_priv(cpu_priv),
      .ctx_sel(ctx_sel), .ctx_primary(PCTX), .ctx_secondary(SCTX), .stat_clr(stat_clr),
      .rsp_valid(rsp_valid), .rsp_exc(rsp_exc), .rsp_perm_rd(rsp_perm_rd),
      .rsp_perm_wr(rsp_perm_wr), .stat_word(stat_word), .fault_addr(fault_addr),
      .tag_access(tag_access)
   );

   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic check_regs(input string rq);
      chk(rq, "status", {54'd0, stat_word}, {54'd0, m_stat});
      chk("R10", "fault_addr", fault_addr, m_far);
      chk("R10", "tag_access", tag_access, m_tag);
   endtask

   // one access; e_ft bits: [0] privilege, [1] nf side effect, [2] no-fault-only
   task automatic access(input logic [63:0] a, input bit p, input bit w, input bit se,
                         input bit nf, input logic [1:0] k, input bit u, input bit cp,
                         input logic [1:0] sel, input bit clr, input logic [1:0] e_exc,
                         input logic [2:0] e_ft, input string rq);
      logic [9:0]       ns;
      logic [CTX_W-1:0] cv;
      logic [1:0]       ct;
      @(negedge clk);
      req_valid = 1'b1; va = a; attr_priv = p; attr_wr_ok = w; attr_side_eff = se;
      attr_nfo = nf; acc_kind = k; acc_user = u; cpu_priv = cp; ctx_sel = sel; stat_clr = clr;
      @(negedge clk);
      req_valid = 1'b0; stat_clr = 1'b0;
      if (clr) m_stat[0] = 1'b0;
      if (e_exc != 2'd0) begin
         cv = (sel == 2'd0) ? PCTX : (sel == 2'd1) ? SCTX : '0;
         ct = (sel == 2'd0) ? 2'd0 : (sel == 2'd1) ? 2'd1 : 2'd2;
         ns = '0;
         ns[0] = 1'b1; ns[1] = m_stat[0]; ns[2] = cp; ns[4:3] = ct;
         ns[5] = (k == 2'd1); ns[6] = (k == 2'd2); ns[9:7] = e_ft;
         m_stat = ns; m_far = a; m_tag = {a[63:13], cv};
      end
      chk("R6", "rsp_valid", {63'd0, rsp_valid}, 64'd1);
      chk(rq, "exc", {62'd0, rsp_exc}, {62'd0, e_exc});
      chk("R6", "perm_rd", {63'd0, rsp_perm_rd}, {63'd0, (e_exc == 2'd0)});
      chk("R6", "perm_wr", {63'd0, rsp_perm_wr}, {63'd0, (e_exc == 2'd0) && w});
      check_regs(rq);
   endtask

   task automatic t_reset;
      chk("R1", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
      chk("R1", "status", {54'd0, stat_word}, 64'd0);
      chk("R1", "fault_addr", fault_addr, 64'd0);
      chk("R1", "tag_access", tag_access, 64'd0);
   endtask

   task automatic t_grants;
      access(64'h0000_1234_5678_9ABC, 0, 1, 0, 0, 2'd0, 1, 0, 2'd0, 0, 2'd0, 3'b000, "R6");
      access(64'h0000_1234_5678_9ABC, 0, 0, 0, 0, 2'd1, 0, 1, 2'd0, 0, 2'd2, 3'b000, "R5");
      access(64'h0000_0000_0040_2000, 1, 1, 0, 0, 2'd1, 0, 1, 2'd1, 0, 2'd0, 3'b000, "R2");
      access(64'h0000_0000_0040_3000, 0, 0, 0, 1, 2'd2, 1, 0, 2'd0, 0, 2'd0, 3'b000, "R3");
      check_regs("R11");
   endtask

   task automatic t_priv_fault;
      access(64'hFFFF_8000_0001_3FFF, 1, 1, 0, 0, 2'd0, 1, 0, 2'd0, 0, 2'd1, 3'b001, "R2");
      access(64'h0000_7000_0000_2ABC, 0, 1, 1, 0, 2'd2, 1, 1, 2'd1, 0, 2'd1, 3'b010, "R3");
      chk("R9", "overwrite", {63'd0, stat_word[1]}, 64'd1);
      chk("R8", "nf bit", {63'd0, stat_word[6]}, 64'd1);
   endtask

   task automatic t_clear_and_multi;
      @(negedge clk); stat_clr = 1'b1;
      @(negedge clk); stat_clr = 1'b0; m_stat[0] = 1'b0;
      check_regs("R11");
      access(64'h0000_0ABC_DEF0_1FFF, 1, 1, 0, 1, 2'd1, 1, 0, 2'd2, 0, 2'd1, 3'b101, "R4");
      chk("R7", "nucleus tag ctx", {51'd0, tag_access[12:0]}, 64'd0);
      access(64'h0000_0000_0000_5000, 0, 0, 0, 1, 2'd0, 0, 1, 2'd3, 0, 2'd1, 3'b100, "R7");
      access(64'h0000_0000_0000_6000, 1, 0, 0, 0, 2'd1, 1, 0, 2'd0, 0, 2'd1, 3'b001, "R5");
      access(64'h0000_0000_0000_7000, 0, 0, 0, 0, 2'd1, 0, 1, 2'd1, 1, 2'd2, 3'b000, "R11");
      chk("R11", "overwrite after clear", {63'd0, stat_word[1]}, 64'd0);
      access(64'h0000_0000_0000_8000, 0, 0, 1, 0, 2'd0, 1, 0, 2'd0, 0, 2'd0, 3'b000, "R3");
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_grants();
      t_priv_fault();
      t_clear_and_multi();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule